// File: doc/BRIEF.md
# Pushbutton Debounce and Pulse Unit

This block cleans up a raw mechanical pushbutton signal. The button input is not tied to the system clock, so it first goes through a chain of synchronising flops. A lockout debouncer follows. It reacts to the first transition it sees and then holds that new level for a fixed number of clock cycles. Contact bounce that falls inside this window has no effect on the output.

The clean level then goes to a registered rising-edge detector. For each press, the detector emits one pulse exactly one clock wide. A typical use is to drive the enable of a counter, so that the counter advances by exactly one step per press, however long the button is held.

The lockout window is a parameter counted in clock cycles. Its default is one millisecond at the default system clock. It should be set longer than the worst bounce time of the switch.

Top module: `button_press_conditioner`

## Requirements
- R1: `button_i` passes through `SYNC_STAGES` flops (default 2). When the debouncer is not locked, a change that `button_i` holds across one rising edge appears on `level_o` after the third rising edge, counting that edge as the first.
- R2: The debouncer does not wait for the input to settle. A first change held for a single clock cycle is accepted and copied to `level_o`.
- R3: After `level_o` changes, it keeps its value for `LOCK_CYCLES` clock cycles, and input changes during that window are ignored. If the synchronised input still differs from `level_o` when the window ends, `level_o` follows it on the next edge, which is `LOCK_CYCLES` edges after the previous change.
- R4: `press_o` (1 = press) is high for exactly one cycle. It is high in the cycle that follows the first cycle in which `level_o` is 1 after being 0.
- R5: A falling transition of `level_o` never produces a pulse on `press_o`.
- R6: `rst_i` is synchronous and active high. While it is asserted, `press_o` is 0, the lockout is cleared, and `level_o` tracks the synchronised input.
- R7: If `rst_i` is released while the button is already held, `level_o` starts at 1 and no pulse is produced.
- R8: A burst of bounces whose transitions all fall within one lockout window, and which ends with the button held, produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| button_i | input | 1 | Raw, asynchronous, bouncing button level (1 = pressed) |
| level_o | output | 1 | Debounced button level |
| press_o | output | 1 | One-cycle pulse per debounced press |

## Verification
The embedded properties check, on every cycle, the following: the press pulse never lasts longer than one cycle; it only appears right after a clean 0-to-1 step and never after a fall; it stays low just after reset; and the debounced level is frozen while the lockout is running. Some behaviours can only be shown by the bench's scenarios, because no single-cycle relation captures them. These are the exact latency through the synchroniser, the exact length of the lockout window, the acceptance of a one-cycle glitch, the single pulse from a bounce burst, and the silent start when reset is released with the button held.

// File: rtl/deb_pkg.sv
package deb_pkg;

  // Strobes the lockout control hands to the level/pulse datapath.
  typedef struct packed {
    logic seed;    // reset phase: load level and history from the input
    logic accept;  // take the synchronised input as the new clean level
  } deb_strobe_t;

endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chainQ;

  always_ff @(posedge clk_i) chainQ[0] <= async_i;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) chainQ[s] <= chainQ[s-1];
    end
  endgenerate

  assign sync_o = chainQ[STAGES-1];

endmodule

// File: rtl/deb_ctrl.sv
module deb_ctrl
  import deb_pkg::*;
#(
  parameter int LOCK_CYCLES = 100_000
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        differ_i,
  output deb_strobe_t strobe_o,
  output logic        locked_o
);

  localparam int CNT_W = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] countQ;
  logic             locked;

  assign locked          = (countQ != '0);
  assign locked_o        = locked;
  assign strobe_o.seed   = rst_i;
  assign strobe_o.accept = !rst_i && !locked && differ_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)                countQ <= '0;
    else if (strobe_o.accept) countQ <= RELOAD;
    else if (locked)          countQ <= countQ - 1'b1;
  end

  // R3: while the window runs, the control never grants a new level
  a_r3_no_accept_locked: assert property (@(posedge clk_i) disable iff (rst_i)
    locked |-> !strobe_o.accept);

  // R6: the window is empty in the cycle after reset
  a_r6_unlocked_after_reset: assert property (@(posedge clk_i)
    rst_i |=> !locked_o);

endmodule

// File: rtl/deb_datapath.sv
module deb_datapath
  import deb_pkg::*;
(
  input  logic        clk_i,
  input  logic        sync_i,
  input  deb_strobe_t strobe_i,
  output logic        differ_o,
  output logic        level_o,
  output logic        press_o
);

  logic levelQ;
  logic prevQ;
  logic pressQ;

  always_ff @(posedge clk_i) begin
    if (strobe_i.seed) begin
      levelQ <= sync_i;
      prevQ  <= sync_i;
      pressQ <= 1'b0;
    end else begin
      if (strobe_i.accept) levelQ <= sync_i;
      prevQ  <= levelQ;
      pressQ <= levelQ & ~prevQ;
    end
  end

  assign differ_o = (sync_i != levelQ);
  assign level_o  = levelQ;
  assign press_o  = pressQ;

  // R4: a pulse is one cycle wide
  a_r4_single_cycle: assert property (@(posedge clk_i) disable iff (strobe_i.seed)
    pressQ |=> !pressQ);

  // R4: a pulse follows a 0-to-1 step of the clean level
  a_r4_follows_rise: assert property (@(posedge clk_i) disable iff (strobe_i.seed)
    pressQ |-> ($past(levelQ) && !$past(levelQ, 2)));

  // R5: a fall of the clean level yields no pulse
  a_r5_no_fall_pulse: assert property (@(posedge clk_i) disable iff (strobe_i.seed)
    $fell(levelQ) |=> !pressQ);

endmodule

// File: rtl/button_press_conditioner.sv
module button_press_conditioner
  import deb_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int LOCK_CYCLES = CLK_HZ / 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic button_i,
  output logic level_o,
  output logic press_o
);

  deb_strobe_t strobe;
  logic        syncBtn;
  logic        differ;
  logic        locked;

  deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .async_i (button_i),
    .sync_o  (syncBtn)
  );

  deb_ctrl #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .differ_i (differ),
    .strobe_o (strobe),
    .locked_o (locked)
  );

  deb_datapath u_dp (
    .clk_i    (clk_i),
    .sync_i   (syncBtn),
    .strobe_i (strobe),
    .differ_o (differ),
    .level_o  (level_o),
    .press_o  (press_o)
  );

  // R3: the clean level is frozen while the lockout runs
  a_r3_hold_in_lockout: assert property (@(posedge clk_i) disable iff (rst_i)
    locked |=> $stable(level_o));

  // R6: no pulse right after a reset cycle
  a_r6_quiet_after_reset: assert property (@(posedge clk_i)
    rst_i |=> !press_o);

endmodule

// File: tb/button_press_conditioner_bench.sv
module button_press_conditioner_bench;

  localparam int LOCK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic level;
  logic press;

  int checks = 0;
  int fails  = 0;
  int pressTotal = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  button_press_conditioner #(.CLK_HZ(1000), .LOCK_CYCLES(LOCK), .SYNC_STAGES(2))
    u_button_press_conditioner (
      .clk_i    (clk),
      .rst_i    (rst),
      .button_i (btn),
      .level_o  (level),
      .press_o  (press)
    );

  always @(negedge clk) if (!rst && press) pressTotal++;

  typedef struct packed {
    logic       b;
    logic [7:0] cyc;
    logic       chk;
    logic       lvl;
    logic [7:0] presses;
  } vec_t;

  // cumulative press count after each vector
  localparam vec_t VECS [12] = '{
    '{1'b1, 8'd20, 1'b1, 1'b1, 8'd1},  // R4 clean press
    '{1'b0, 8'd20, 1'b1, 1'b0, 8'd1},  // R5 release, no pulse
    '{1'b1, 8'd1,  1'b0, 1'b0, 8'd0},  // R8 bounce burst
    '{1'b0, 8'd1,  1'b0, 1'b0, 8'd0},
    '{1'b1, 8'd1,  1'b0, 1'b0, 8'd0},
    '{1'b0, 8'd1,  1'b0, 1'b0, 8'd0},
    '{1'b1, 8'd20, 1'b1, 1'b1, 8'd2},  // R8 one pulse only
    '{1'b0, 8'd3,  1'b0, 1'b0, 8'd0},  // R3 short release
    '{1'b1, 8'd20, 1'b1, 1'b1, 8'd3},  // R3 followed after window
    '{1'b0, 8'd1,  1'b0, 1'b0, 8'd0},  // R2 one-cycle glitch
    '{1'b1, 8'd20, 1'b1, 1'b1, 8'd4},  // R2 glitch taken, R3 recovery
    '{1'b0, 8'd20, 1'b1, 1'b0, 8'd4}   // R5
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20_000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R6: reset state
    step(5);
    check("R6 press in reset", int'(press), 0);
    check("R6 level in reset", int'(level), 0);
    rst = 1'b0;
    step(3);
    check("R6 level after release", int'(level), 0);

    // R1 / R4 / R3: exact latency and lockout length
    btn = 1'b1;           // n0
    step(1); btn = 1'b0;  // n1: raw pulse one cycle wide
    step(1);              // n2
    check("R1 level before latency", int'(level), 0);
    step(1);              // n3
    check("R1 level after latency", int'(level), 1);
    check("R4 no pulse with level", int'(press), 0);
    step(1);              // n4
    check("R4 pulse one cycle later", int'(press), 1);
    step(1);              // n5
    check("R4 pulse one cycle wide", int'(press), 0);
    step(5);              // n10
    check("R3 level held to window end", int'(level), 1);
    step(1);              // n11
    check("R3 level follows after window", int'(level), 0);
    step(20);
    check("R4 pulse count", pressTotal, 1);
    pressTotal = 0;

    // vector table
    for (int i = 0; i < 12; i++) begin
      btn = VECS[i].b;
      step(int'(VECS[i].cyc));
      if (VECS[i].chk) begin
        check($sformatf("vec%0d level", i), int'(level), int'(VECS[i].lvl));
        check($sformatf("vec%0d presses", i), pressTotal, int'(VECS[i].presses));
      end
    end

    // R7: release reset with button held
    rst = 1'b1;
    btn = 1'b1;
    step(5);
    check("R6 level tracks input in reset", int'(level), 1);
    check("R6 press low in reset", int'(press), 0);
    pressTotal = 0;
    rst = 1'b0;
    step(1);
    check("R7 level high at release", int'(level), 1);
    step(20);
    check("R7 no pulse at release", pressTotal, 0);

    // R6: reset mid-lockout clears window
    btn = 1'b0;
    step(4);              // accepted, lockout running
    rst = 1'b1;
    btn = 1'b1;
    step(4);
    rst = 1'b0;
    step(1);
    check("R6 level reseeded", int'(level), 1);
    step(10);
    check("R6 no pulse after reseed", pressTotal, 0);

    finish_run();
  end

endmodule